// File: doc/BRIEF.md
# Start-up and Standby Sequencer

This block decides when a small 4-bit controller core may run. It watches the external active-low reset and hold-control pins, an oscillator-ready flag from the clock generator and the core's instruction-cycle strobe. Once a reset has been accepted and then released, it opens a fixed configuration window. During that window it reads port option words from the top of program memory while every port is kept open-drain. When the window closes, it clears the program counter and lets the core execute.

During execution the core may ask to halt or to enter hold. In halt, ports keep driving and the oscillator keeps running. In hold, the oscillator is stopped and every port is switched off. While the hold pin is low, the reset pin has no effect. The way out of hold is to raise the hold pin. That forces the whole start-up sequence to run again, so a fresh reset pulse is needed and the options are read again.

Top module: `boot_standby_top`

## Requirements
- R1: Whenever `resetPinN` is low, `portPullEn` is all zeros (every port bit open-drain, where 1 would mean the active pull-up or push-pull driver is enabled). This holds in every state.
- R2: A reset is accepted only when `resetPinN` is seen low on at least 3 `cycStrobe` cycles after `oscStable` is high, with `holdPinN` high. A shorter low pulse followed by release leaves `coreRst` high and starts no configuration window.
- R3: After an accepted reset is released, the configuration window lasts exactly 9 `cycStrobe` cycles. Through the window `coreRst` stays high and `portPullEn` stays zero.
- R4: On the clock that follows the 9th strobe of the window, `pcClear` is high for exactly one clock and `coreRst` drops to 0.
- R5: In the window, `optRd` is high for the first 5 strobe cycles only. On read k (k = 0..4), `optAddr` is 0x3FF0 + k. The address advances by one on each strobe. `optRd` is never high outside the window.
- R6: Option word k, for k = 0..3, becomes `portPullEn[8k+7:8k]`. Bits [4:0] of word 4 become `resetLevel`, one bit per 4-bit group, in the group order port 0, 1, 4, 5, 8, where 1 means high. These values are held until the next window.
- R7: While `holdPinN` is low, a low `resetPinN` does not raise `coreRst` and does not leave run, halt or hold.
- R8: In run, a `holdReq` with `holdPinN` low enters hold. A later high level on `holdPinN` raises `coreRst` and requires the full sequence again: osc-ready, minimum reset low and a new 9-cycle window that reloads the options.
- R9: In hold, `portsOff` = 1 and `oscRun` = 0. In halt (`haltReq` high in run), `portsOff` = 0, `oscRun` = 1 and `portPullEn` keeps its value. Halt ends when `haltReq` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset of the sequencer flops, active low |
| resetPinN | input | 1 | External reset pin, active low, already synchronised |
| holdPinN | input | 1 | External hold-control pin, active low, already synchronised |
| oscStable | input | 1 | Main oscillator has settled |
| cycStrobe | input | 1 | One-clock pulse per instruction cycle |
| haltReq | input | 1 | Core requests halt (level) |
| holdReq | input | 1 | Core executes a hold request (pulse) |
| optData | input | 8 | Program-memory data for `optAddr`, valid in the same clock |
| optRd | output | 1 | Option read in progress |
| optAddr | output | 14 | Program-memory address of the option word |
| coreRst | output | 1 | Core held in reset |
| pcClear | output | 1 | One-clock program-counter clear |
| portPullEn | output | 32 | Per-bit output driver enable, 0 = open-drain |
| resetLevel | output | 5 | Reset output level per port group |
| portsOff | output | 1 | All port outputs disabled |
| oscRun | output | 1 | Oscillator enable |

## Verification
The assertions take for granted three things about the inputs. `cycStrobe` is a single-clock pulse. `optData` answers `optAddr` combinationally. `holdReq` only matters in run. The stimulus respects this. Every strobe is one clock wide and separated from the next. The bench memory model is a pure function of the address. `holdReq` is pulsed only after the sequencer has reached run. Pin changes are made away from strobes, so each state change can be tied to a known cycle.

// File: rtl/boot_standby_pkg.sv
package boot_standby_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_OSC,
    ST_RESET_HOLD,
    ST_OPTION_LOAD,
    ST_RUN,
    ST_HALT,
    ST_HOLD
  } seqState_e;

  typedef struct packed {
    logic optActive;
    logic optStep;
    logic forceOd;
    logic portsOff;
    logic oscOff;
  } seqCtl_t;

endpackage

// File: rtl/boot_standby_ctrl.sv
module boot_standby_ctrl
  import boot_standby_pkg::*;
#(
  parameter int RST_MIN_CYC = 3,
  parameter int CFG_CYC     = 9
) (
  input  logic    clk,
  input  logic    porN,
  input  logic    resetPinN,
  input  logic    holdPinN,
  input  logic    oscStable,
  input  logic    cycStrobe,
  input  logic    haltReq,
  input  logic    holdReq,
  output logic    coreRst,
  output logic    pcClear,
  output seqCtl_t ctl
);

  localparam int CNT_MAX = (CFG_CYC > RST_MIN_CYC) ? CFG_CYC : RST_MIN_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RST_MIN_CYC);
  localparam logic [CNT_W-1:0] CFG_LAST = CNT_W'(CFG_CYC - 1);

  seqState_e state, nextState;
  logic [CNT_W-1:0] cnt, cntNext;
  logic rstAccept;

  assign rstAccept = !resetPinN && holdPinN;

  always_comb begin
    nextState = state;
    cntNext   = cnt;
    case (state)
      ST_WAIT_OSC: begin
        if (oscStable) begin
          nextState = ST_RESET_HOLD;
          cntNext   = '0;
        end
      end
      ST_RESET_HOLD: begin
        if (!oscStable) begin
          nextState = ST_WAIT_OSC;
          cntNext   = '0;
        end else if (!holdPinN) begin
          cntNext = '0;
        end else if (!resetPinN) begin
          if (cycStrobe && cnt < RST_LIM) cntNext = cnt + 1'b1;
        end else if (cnt == RST_LIM) begin
          nextState = ST_OPTION_LOAD;
          cntNext   = '0;
        end else begin
          cntNext = '0;
        end
      end
      ST_OPTION_LOAD: begin
        if (rstAccept) begin
          nextState = oscStable ? ST_RESET_HOLD : ST_WAIT_OSC;
          cntNext   = '0;
        end else if (cycStrobe) begin
          if (cnt == CFG_LAST) begin
            nextState = ST_RUN;
            cntNext   = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (rstAccept) begin
          nextState = oscStable ? ST_RESET_HOLD : ST_WAIT_OSC;
          cntNext   = '0;
        end else if (holdReq && !holdPinN) begin
          nextState = ST_HOLD;
        end else if (haltReq) begin
          nextState = ST_HALT;
        end
      end
      ST_HALT: begin
        if (rstAccept) begin
          nextState = oscStable ? ST_RESET_HOLD : ST_WAIT_OSC;
          cntNext   = '0;
        end else if (!haltReq) begin
          nextState = ST_RUN;
        end
      end
      ST_HOLD: begin
        if (holdPinN) begin
          nextState = ST_WAIT_OSC;
          cntNext   = '0;
        end
      end
      default: begin
        nextState = ST_WAIT_OSC;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state   <= ST_WAIT_OSC;
      cnt     <= '0;
      pcClear <= 1'b0;
    end else begin
      state   <= nextState;
      cnt     <= cntNext;
      pcClear <= (state == ST_OPTION_LOAD) && (nextState == ST_RUN);
    end
  end

  assign coreRst       = (state == ST_WAIT_OSC) || (state == ST_RESET_HOLD) ||
                         (state == ST_OPTION_LOAD);
  assign ctl.optActive = (state == ST_OPTION_LOAD);
  assign ctl.optStep   = (state == ST_OPTION_LOAD) && cycStrobe;
  assign ctl.forceOd   = coreRst || !resetPinN;
  assign ctl.portsOff  = (state == ST_HOLD);
  assign ctl.oscOff    = (state == ST_HOLD);

  AST_PCCLR_SINGLE: assert property (@(posedge clk) disable iff (!porN)
    pcClear |=> !pcClear); // R4
  AST_PCCLR_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!porN)
    pcClear |-> (state == ST_RUN) && ($past(state) == ST_OPTION_LOAD)); // R3
  AST_HOLD_BLOCKS_RESET: assert property (@(posedge clk) disable iff (!porN)
    ((state == ST_RUN || state == ST_HALT || state == ST_HOLD) && !holdPinN)
      |=> !coreRst); // R7
  AST_START_AFTER_MIN_LOW: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_OPTION_LOAD && $past(state) == ST_RESET_HOLD)
      |-> $past(cnt) == RST_LIM); // R2

endmodule

// File: rtl/boot_standby_opt_dp.sv
module boot_standby_opt_dp
  import boot_standby_pkg::*;
#(
  parameter int          ADDR_W    = 14,
  parameter int          DATA_W    = 8,
  parameter int          NUM_PORTS = 8,
  parameter int          NUM_LVL   = 5,
  parameter logic [13:0] OPT_BASE  = 14'h3FF0
) (
  input  logic                     clk,
  input  logic                     porN,
  input  seqCtl_t                  ctl,
  input  logic [DATA_W-1:0]        optData,
  output logic                     optRd,
  output logic [ADDR_W-1:0]        optAddr,
  output logic [NUM_PORTS*4-1:0]   portPullEn,
  output logic [NUM_LVL-1:0]       resetLevel,
  output logic                     portsOff,
  output logic                     oscRun
);

  localparam int TYPE_BITS  = NUM_PORTS * 4;
  localparam int TYPE_WORDS = TYPE_BITS / DATA_W;
  localparam int OPT_WORDS  = TYPE_WORDS + 1;
  localparam int IDX_W      = $clog2(OPT_WORDS + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(OPT_WORDS);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] optWord [OPT_WORDS];
  logic [TYPE_BITS-1:0] typeBits;

  assign optRd   = ctl.optActive && (idx < IDX_END);
  assign optAddr = ADDR_W'(OPT_BASE) + ADDR_W'(idx);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      idx <= '0;
      for (int w = 0; w < OPT_WORDS; w++) optWord[w] <= '0;
    end else if (!ctl.optActive) begin
      idx <= '0;
    end else if (ctl.optStep && (idx < IDX_END)) begin
      optWord[idx] <= optData;
      idx          <= idx + 1'b1;
    end
  end

  for (genvar k = 0; k < TYPE_WORDS; k++) begin : g_type
    assign typeBits[k*DATA_W +: DATA_W] = optWord[k];
  end

  assign portPullEn = ctl.forceOd ? '0 : typeBits;
  assign resetLevel = optWord[TYPE_WORDS][NUM_LVL-1:0];
  assign portsOff   = ctl.portsOff;
  assign oscRun     = !ctl.oscOff;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!porN)
    idx <= IDX_END); // R5
  AST_IDX_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (!porN)
    !ctl.optActive |=> (idx == '0) || ctl.optActive); // R5

endmodule

// File: rtl/boot_standby_top.sv
module boot_standby_top
  import boot_standby_pkg::*;
#(
  parameter int          ADDR_W      = 14,
  parameter int          DATA_W      = 8,
  parameter int          NUM_PORTS   = 8,
  parameter int          NUM_LVL     = 5,
  parameter int          RST_MIN_CYC = 3,
  parameter int          CFG_CYC     = 9,
  parameter logic [13:0] OPT_BASE    = 14'h3FF0
) (
  input  logic                   clk,
  input  logic                   porN,
  input  logic                   resetPinN,
  input  logic                   holdPinN,
  input  logic                   oscStable,
  input  logic                   cycStrobe,
  input  logic                   haltReq,
  input  logic                   holdReq,
  input  logic [DATA_W-1:0]      optData,
  output logic                   optRd,
  output logic [ADDR_W-1:0]      optAddr,
  output logic                   coreRst,
  output logic                   pcClear,
  output logic [NUM_PORTS*4-1:0] portPullEn,
  output logic [NUM_LVL-1:0]     resetLevel,
  output logic                   portsOff,
  output logic                   oscRun
);

  seqCtl_t ctl;

  boot_standby_ctrl #(
    .RST_MIN_CYC(RST_MIN_CYC),
    .CFG_CYC    (CFG_CYC)
  ) u_ctrl (
    .clk      (clk),
    .porN     (porN),
    .resetPinN(resetPinN),
    .holdPinN (holdPinN),
    .oscStable(oscStable),
    .cycStrobe(cycStrobe),
    .haltReq  (haltReq),
    .holdReq  (holdReq),
    .coreRst  (coreRst),
    .pcClear  (pcClear),
    .ctl      (ctl)
  );

  boot_standby_opt_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_PORTS(NUM_PORTS),
    .NUM_LVL  (NUM_LVL),
    .OPT_BASE (OPT_BASE)
  ) u_dp (
    .clk       (clk),
    .porN      (porN),
    .ctl       (ctl),
    .optData   (optData),
    .optRd     (optRd),
    .optAddr   (optAddr),
    .portPullEn(portPullEn),
    .resetLevel(resetLevel),
    .portsOff  (portsOff),
    .oscRun    (oscRun)
  );

  AST_RESET_PIN_FORCES_OD: assert property (@(posedge clk) disable iff (!porN)
    !resetPinN |-> portPullEn == '0); // R1
  AST_READ_ONLY_IN_RESET: assert property (@(posedge clk) disable iff (!porN)
    optRd |-> coreRst && !pcClear); // R5
  AST_HOLD_ENTRY_NEEDS_PIN: assert property (@(posedge clk) disable iff (!porN)
    $rose(portsOff) |-> $past(!holdPinN)); // R8
  AST_HOLD_NOT_IN_RESET: assert property (@(posedge clk) disable iff (!porN)
    portsOff |-> !coreRst); // R9

endmodule

// File: tb/boot_standby_top_tb.sv
module boot_standby_top_tb;

  logic        clk = 1'b0;
  logic        porN, resetPinN, holdPinN, oscStable, cycStrobe, haltReq, holdReq;
  logic [7:0]  optData;
  logic        optRd, coreRst, pcClear, portsOff, oscRun;
  logic [13:0] optAddr;
  logic [31:0] portPullEn;
  logic [4:0]  resetLevel;
  logic [7:0]  romSalt;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] romWord(input logic [13:0] a, input logic [7:0] salt);
    logic [7:0] base;
    case (a)
      14'h3FF0: base = 8'hA5;
      14'h3FF1: base = 8'h3C;
      14'h3FF2: base = 8'hF0;
      14'h3FF3: base = 8'h96;
      14'h3FF4: base = 8'h15;
      default:  base = 8'h00;
    endcase
    return (a >= 14'h3FF0 && a <= 14'h3FF4) ? (base ^ salt) : base;
  endfunction

  assign optData = romWord(optAddr, romSalt);

  boot_standby_top u_dut (
    .clk(clk), .porN(porN), .resetPinN(resetPinN), .holdPinN(holdPinN),
    .oscStable(oscStable), .cycStrobe(cycStrobe), .haltReq(haltReq),
    .holdReq(holdReq), .optData(optData), .optRd(optRd), .optAddr(optAddr),
    .coreRst(coreRst), .pcClear(pcClear), .portPullEn(portPullEn),
    .resetLevel(resetLevel), .portsOff(portsOff), .oscRun(oscRun)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) cycStrobe = 1'b1;
    @(negedge clk) cycStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Holds reset low for the minimum, releases it, walks the window.
  task automatic startup(input logic [7:0] salt);
    logic [7:0] w [5];
    romSalt = salt;
    for (int k = 0; k < 5; k++) w[k] = romWord(14'h3FF0 + 14'(k), salt);
    resetPinN = 1'b0;
    idle(1);
    check("R1", "od while reset low", portPullEn, 32'h0);
    for (int i = 0; i < 3; i++) strobe();
    @(negedge clk) resetPinN = 1'b1;
    idle(1);
    for (int i = 0; i < 9; i++) begin
      check("R3", "coreRst in window", {31'h0, coreRst}, 32'h1);
      check("R3", "od in window", portPullEn, 32'h0);
      check("R5", "optRd in window", {31'h0, optRd}, {31'h0, (i < 5)});
      if (i < 5) check("R5", "optAddr", {18'h0, optAddr}, 32'h3FF0 + i);
      strobe();
    end
    check("R4", "pcClear after window", {31'h0, pcClear}, 32'h1);
    check("R4", "coreRst released", {31'h0, coreRst}, 32'h0);
    idle(1);
    check("R4", "pcClear one clock", {31'h0, pcClear}, 32'h0);
    check("R5", "no read after window", {31'h0, optRd}, 32'h0);
    check("R6", "pull enables", portPullEn, {w[3], w[2], w[1], w[0]});
    check("R6", "reset levels", {27'h0, resetLevel}, {27'h0, w[4][4:0]});
  endtask

  task automatic tShortPulse();
    resetPinN = 1'b0;
    strobe();
    strobe();
    @(negedge clk) resetPinN = 1'b1;
    idle(3);
    check("R2", "short pulse keeps reset", {31'h0, coreRst}, 32'h1);
    check("R2", "short pulse no window", {31'h0, optRd}, 32'h0);
  endtask

  task automatic tHoldBlocksReset();
    logic [31:0] saved = portPullEn;
    holdPinN = 1'b0;
    idle(1);
    resetPinN = 1'b0;
    for (int i = 0; i < 4; i++) strobe();
    check("R7", "no core reset while hold low", {31'h0, coreRst}, 32'h0);
    check("R1", "od while reset low in run", portPullEn, 32'h0);
    @(negedge clk) resetPinN = 1'b1;
    holdPinN = 1'b1;
    idle(1);
    check("R7", "options intact", portPullEn, saved);
  endtask

  task automatic tHalt();
    logic [31:0] saved = portPullEn;
    haltReq = 1'b1;
    idle(3);
    check("R9", "halt ports on", {31'h0, portsOff}, 32'h0);
    check("R9", "halt osc runs", {31'h0, oscRun}, 32'h1);
    check("R9", "halt retains", portPullEn, saved);
    check("R9", "halt no reset", {31'h0, coreRst}, 32'h0);
    haltReq = 1'b0;
    idle(2);
  endtask

  task automatic tHold();
    holdPinN = 1'b0;
    idle(1);
    holdReq = 1'b1;
    idle(1);
    holdReq = 1'b0;
    idle(1);
    check("R9", "hold ports off", {31'h0, portsOff}, 32'h1);
    check("R9", "hold osc stopped", {31'h0, oscRun}, 32'h0);
    oscStable = 1'b0;
    resetPinN = 1'b0;
    for (int i = 0; i < 4; i++) strobe();
    check("R7", "reset ignored in hold", {31'h0, portsOff}, 32'h1);
    check("R7", "no core reset in hold", {31'h0, coreRst}, 32'h0);
    @(negedge clk) holdPinN = 1'b1;
    idle(1);
    check("R8", "hold exit resets core", {31'h0, coreRst}, 32'h1);
    check("R8", "hold exit osc on", {31'h0, oscRun}, 32'h1);
    check("R8", "hold exit ports on", {31'h0, portsOff}, 32'h0);
    idle(2);
    oscStable = 1'b1;
    idle(1);
    startup(8'h0F);
  endtask

  initial begin
    porN = 1'b0; resetPinN = 1'b0; holdPinN = 1'b1; oscStable = 1'b0;
    cycStrobe = 1'b0; haltReq = 1'b0; holdReq = 1'b0; romSalt = 8'h00;
    idle(2);
    check("R3", "reset state coreRst", {31'h0, coreRst}, 32'h1);
    check("R4", "reset state pcClear", {31'h0, pcClear}, 32'h0);
    check("R1", "reset state od", portPullEn, 32'h0);
    check("R5", "reset state optRd", {31'h0, optRd}, 32'h0);
    porN = 1'b1;
    for (int i = 0; i < 4; i++) strobe();
    check("R2", "no start before osc", {31'h0, optRd}, 32'h0);
    oscStable = 1'b1;
    idle(2);
    tShortPulse();
    startup(8'h00);
    tHoldBlocksReset();
    tHalt();
    tHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule